// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits on the host side of a parallel NOR flash bus and runs the command sequences that program, erase, suspend, resume and protect the device. A client pulses a start request with an operation code, a target address and up to four data words. The sequencer then issues the bus writes for that operation and polls the device status word until the ready bit reports completion. It decodes any error flags, clears the device status when an error is present and always leaves the device in read-array mode. Completion is signalled by a one-cycle done pulse together with an error code.

Each bus access takes one clock. A write is one cycle with `fl_we` high. A read is one cycle with `fl_re` high, and `fl_rdata` is sampled at the end of that cycle. A programmable poll limit stops a device that never becomes ready from hanging the block.

Operation codes on `req_op`:

| Code | Operation |
|------|-----------|
| 0 | single-word program |
| 1 | two-word program |
| 2 | four-word program |
| 3 | block erase |
| 4 | suspend |
| 5 | resume |
| 6 | lock |
| 7 | unlock |
| 8 | lock-down |

Codes 9 to 15 are illegal. Data word k is `req_data[16k+15:16k]`.

Error codes on `err_code`:

| Code | Meaning |
|------|---------|
| 0 | ok |
| 1 | supply fault |
| 2 | program failure |
| 3 | erase failure |
| 4 | sequence error |
| 5 | protected block |
| 6 | poll timeout |
| 7 | lock readback mismatch |

Top module: `flash_pe_sequencer`

## Requirements
- R1: A single-word program writes 40h at the request address, then the data word at that address, then polls status reads until bit 7 of the status is 1.
- R2: A two-word program writes 30h, then words 0 and 1 at the request address with A0 forced to 0 and then 1. A four-word program writes the QUAD_CODE setup (default 56h), then words 0..3 at the request address with A1:A0 forced to 0,1,2,3.
- R3: A block erase writes 20h and then D0h, both at the request address, and then polls as in R1.
- R4: On the ready status, error checks run in a fixed order and only the first hit is reported. Bit 3 gives code 1. Bits 4 and 5 together give code 4. Bit 4 alone gives code 2. Bit 5 alone gives code 3. Bit 1 gives code 5. No error bit gives code 0.
- R5: When code 1 to 5 is reported from a ready status, a 50h write (clear status) precedes the final FFh write.
- R6: If `poll_limit` consecutive status reads all show bit 7 low, the flow ends with code 6 after exactly that many reads, without the 50h write.
- R7: A suspend writes B0h and then 70h, and polls. If the ready status has bit 6 or bit 2 set, `suspended` is 1 and the code is 0. Otherwise the status is checked as in R4. A resume writes D0h and then polls and checks as for a program.
- R8: Lock, unlock and lock-down write 60h and then 01h, D0h or 2Fh at the request address. They then write 90h and read that address once. The flow reports code 7 if the readback disagrees: lock needs DQ0=1, unlock needs DQ0=0, and lock-down needs DQ1=1.
- R9: Every flow ends with an FFh write at the request address. `done` pulses for one cycle in the clock after that write.
- R10: An illegal operation code causes no bus write other than the final FFh and reports code 4.
- R11: A start request while `busy` is high is ignored: the running bus sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | One-cycle request pulse, taken when idle |
| req_op | input | 4 | Operation code |
| req_addr | input | AW | Target word or block address |
| req_data | input | MAXW*DW | Data words, word k at bits [DW*k +: DW] |
| poll_limit | input | PW | Maximum number of not-ready status reads |
| busy | output | 1 | A flow is running |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result code, held until the next request |
| suspended | output | 1 | Last suspend was taken by the device |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | DW | Flash bus write data |
| fl_rdata | input | DW | Flash bus read data |
| fl_we | output | 1 | Write strobe, one cycle per bus write |
| fl_re | output | 1 | Read strobe, one cycle per bus read |

## Verification
The bench builds the block with its defaults: a 22-bit address, 16-bit data, four data words and a 16-bit poll counter. This makes both the two-word and the four-word address alignment reachable, including the wrap of the low address bits. The poll limit is a port, so the bench sets it to 5 at run time and exercises the timeout path in a handful of cycles. A behavioural device model answers status reads after a chosen number of busy polls with a chosen status word. This lets every branch of the error priority and the suspend decision be selected directly.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

   typedef enum logic [3:0] {
      OP_WORD     = 4'd0,
      OP_DUAL     = 4'd1,
      OP_QUAD     = 4'd2,
      OP_ERASE    = 4'd3,
      OP_SUSPEND  = 4'd4,
      OP_RESUME   = 4'd5,
      OP_LOCK     = 4'd6,
      OP_UNLOCK   = 4'd7,
      OP_LOCKDOWN = 4'd8
   } op_e;

   typedef enum logic [2:0] {
      E_OK      = 3'd0,
      E_VPP     = 3'd1,
      E_PROG    = 3'd2,
      E_ERASE   = 3'd3,
      E_SEQ     = 3'd4,
      E_PROT    = 3'd5,
      E_TIMEOUT = 3'd6,
      E_VERIFY  = 3'd7
   } err_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_SETUP,
      S_SETUP2,
      S_DATA,
      S_IDCMD,
      S_LREAD,
      S_POLL,
      S_CLEAR,
      S_FINAL
   } st_e;

   localparam logic [7:0] C_PROG1   = 8'h40;
   localparam logic [7:0] C_PROG2   = 8'h30;
   localparam logic [7:0] C_ERASE   = 8'h20;
   localparam logic [7:0] C_CONFIRM = 8'hD0;
   localparam logic [7:0] C_SUSP    = 8'hB0;
   localparam logic [7:0] C_RDSTAT  = 8'h70;
   localparam logic [7:0] C_LKSET   = 8'h60;
   localparam logic [7:0] C_LOCK    = 8'h01;
   localparam logic [7:0] C_LKDOWN  = 8'h2F;
   localparam logic [7:0] C_IDREAD  = 8'h90;
   localparam logic [7:0] C_CLRSTAT = 8'h50;
   localparam logic [7:0] C_ARRAY   = 8'hFF;

endpackage

// File: rtl/fpe_status_eval.sv
module fpe_status_eval
   import fpe_pkg::*;
(
   input  logic [7:0] sr,
   input  logic       is_suspend,
   output err_e       code,
   output logic       susp_taken
);

   always_comb begin
      if (sr[3])               code = E_VPP;
      else if (sr[4] && sr[5]) code = E_SEQ;
      else if (sr[4])          code = E_PROG;
      else if (sr[5])          code = E_ERASE;
      else if (sr[1])          code = E_PROT;
      else                     code = E_OK;
   end

   assign susp_taken = is_suspend && (sr[6] || sr[2]);

endmodule

// File: rtl/fpe_poll_timer.sv
module fpe_poll_timer #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic [PW-1:0] limit,
   output logic          expired
);

   logic [PW-1:0] cnt;
   logic [PW:0]   next_cnt;

   if (PW < 2) begin : g_bad_pw
      $error("fpe_poll_timer: PW must be at least 2");
   end

   assign next_cnt = {1'b0, cnt} + {{PW{1'b0}}, 1'b1};
   assign expired  = step && (next_cnt >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (step)   cnt <= next_cnt[PW-1:0];
   end

   assert_cnt_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0));

endmodule

// File: rtl/fpe_word_pick.sv
module fpe_word_pick #(
   parameter int AW   = 22,
   parameter int DW   = 16,
   parameter int MAXW = 4,
   parameter int IDXW = 2
) (
   input  logic [AW-1:0]      base,
   input  logic [MAXW*DW-1:0] words,
   input  logic [IDXW-1:0]    idx,
   input  logic [1:0]         span,
   output logic [AW-1:0]      waddr,
   output logic [DW-1:0]      wdata
);

   if (AW <= IDXW) begin : g_bad_aw
      $error("fpe_word_pick: AW must exceed IDXW");
   end

   for (genvar i = 0; i < AW; i++) begin : g_abit
      if (i < IDXW) begin : g_low
         assign waddr[i] = (32'(span) > i) ? idx[i] : base[i];
      end else begin : g_high
         assign waddr[i] = base[i];
      end
   end

   if (MAXW == 1) begin : g_single
      assign wdata = words[DW-1:0];
   end else begin : g_multi
      assign wdata = words[idx*DW +: DW];
   end

endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
   import fpe_pkg::*;
#(
   parameter int         AW        = 22,
   parameter int         DW        = 16,
   parameter int         MAXW      = 4,
   parameter int         PW        = 16,
   parameter logic [7:0] QUAD_CODE = 8'h56
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_start,
   input  logic [3:0]         req_op,
   input  logic [AW-1:0]      req_addr,
   input  logic [MAXW*DW-1:0] req_data,
   input  logic [PW-1:0]      poll_limit,
   output logic               busy,
   output logic               done,
   output logic [2:0]         err_code,
   output logic               suspended,
   output logic [AW-1:0]      fl_addr,
   output logic [DW-1:0]      fl_wdata,
   input  logic [DW-1:0]      fl_rdata,
   output logic               fl_we,
   output logic               fl_re
);

   localparam int IDXW = (MAXW > 1) ? $clog2(MAXW) : 1;

   if (!(MAXW == 1 || MAXW == 2 || MAXW == 4)) begin : g_bad_maxw
      $error("flash_pe_sequencer: MAXW must be 1, 2 or 4");
   end
   if (DW < 8) begin : g_bad_dw
      $error("flash_pe_sequencer: DW must be at least 8");
   end

   st_e                state;
   logic [3:0]         op_q;
   logic [AW-1:0]      addr_q;
   logic [MAXW*DW-1:0] data_q;
   logic [IDXW-1:0]    idx;
   logic [7:0]         sr_q;
   err_e               err_q;
   logic               done_q;
   logic               susp_q;

   // Which multi-word widths this build supports.
   logic dual_ok, quad_ok;
   if (MAXW >= 4) begin : g_quad
      assign dual_ok = 1'b1;
      assign quad_ok = 1'b1;
   end else if (MAXW == 2) begin : g_dual
      assign dual_ok = 1'b1;
      assign quad_ok = 1'b0;
   end else begin : g_one
      assign dual_ok = 1'b0;
      assign quad_ok = 1'b0;
   end

   logic op_legal;
   always_comb begin
      case (req_op)
         OP_WORD, OP_ERASE, OP_SUSPEND, OP_RESUME,
         OP_LOCK, OP_UNLOCK, OP_LOCKDOWN: op_legal = 1'b1;
         OP_DUAL: op_legal = dual_ok;
         OP_QUAD: op_legal = quad_ok;
         default: op_legal = 1'b0;
      endcase
   end

   logic is_prog, is_erase, is_lock;
   assign is_prog  = (op_q == OP_WORD) || (op_q == OP_DUAL) || (op_q == OP_QUAD);
   assign is_erase = (op_q == OP_ERASE);
   assign is_lock  = (op_q == OP_LOCK) || (op_q == OP_UNLOCK) || (op_q == OP_LOCKDOWN);

   logic [1:0]      span;
   logic [IDXW-1:0] last_idx;
   always_comb begin
      case (op_q)
         OP_DUAL: span = 2'd1;
         OP_QUAD: span = 2'd2;
         default: span = 2'd0;
      endcase
      last_idx = IDXW'((32'd1 << span) - 32'd1);
   end

   logic [AW-1:0] word_addr;
   logic [DW-1:0] word_data;

   fpe_word_pick #(
      .AW(AW), .DW(DW), .MAXW(MAXW), .IDXW(IDXW)
   ) u_pick (
      .base  (addr_q),
      .words (data_q),
      .idx   (idx),
      .span  (span),
      .waddr (word_addr),
      .wdata (word_data)
   );

   err_e eval_code;
   logic susp_taken;

   fpe_status_eval u_eval (
      .sr         (fl_rdata[7:0]),
      .is_suspend (op_q == OP_SUSPEND),
      .code       (eval_code),
      .susp_taken (susp_taken)
   );

   logic poll_step, poll_expired;
   assign poll_step = (state == S_POLL) && !fl_rdata[7];

   fpe_poll_timer #(.PW(PW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state != S_POLL),
      .step    (poll_step),
      .limit   (poll_limit),
      .expired (poll_expired)
   );

   // Readback check for the lock family: DQ0 = locked, DQ1 = locked-down.
   logic lock_match;
   always_comb begin
      case (op_q)
         OP_LOCK:     lock_match = fl_rdata[0];
         OP_UNLOCK:   lock_match = !fl_rdata[0];
         OP_LOCKDOWN: lock_match = fl_rdata[1];
         default:     lock_match = 1'b1;
      endcase
   end

   logic [7:0] setup_cmd, second_cmd;
   always_comb begin
      case (op_q)
         OP_WORD:    setup_cmd = C_PROG1;
         OP_DUAL:    setup_cmd = C_PROG2;
         OP_QUAD:    setup_cmd = QUAD_CODE;
         OP_ERASE:   setup_cmd = C_ERASE;
         OP_SUSPEND: setup_cmd = C_SUSP;
         OP_RESUME:  setup_cmd = C_CONFIRM;
         default:    setup_cmd = C_LKSET;
      endcase
      case (op_q)
         OP_LOCK:     second_cmd = C_LOCK;
         OP_LOCKDOWN: second_cmd = C_LKDOWN;
         default:     second_cmd = C_CONFIRM;
      endcase
   end

   // Bus drive: one strobe per state.
   always_comb begin
      fl_we    = 1'b0;
      fl_re    = 1'b0;
      fl_addr  = addr_q;
      fl_wdata = '0;
      case (state)
         S_SETUP: begin
            fl_we    = 1'b1;
            fl_wdata = DW'(setup_cmd);
         end
         S_SETUP2: begin
            fl_we    = 1'b1;
            fl_wdata = DW'(C_RDSTAT);
         end
         S_DATA: begin
            fl_we = 1'b1;
            if (is_prog) begin
               fl_addr  = word_addr;
               fl_wdata = word_data;
            end else begin
               fl_wdata = DW'(second_cmd);
            end
         end
         S_IDCMD: begin
            fl_we    = 1'b1;
            fl_wdata = DW'(C_IDREAD);
         end
         S_LREAD, S_POLL: fl_re = 1'b1;
         S_CLEAR: begin
            fl_we    = 1'b1;
            fl_wdata = DW'(C_CLRSTAT);
         end
         S_FINAL: begin
            fl_we    = 1'b1;
            fl_wdata = DW'(C_ARRAY);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         op_q   <= '0;
         addr_q <= '0;
         data_q <= '0;
         idx    <= '0;
         sr_q   <= '0;
         err_q  <= E_OK;
         done_q <= 1'b0;
         susp_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            S_IDLE: begin
               if (req_start) begin
                  op_q   <= req_op;
                  addr_q <= req_addr;
                  data_q <= req_data;
                  idx    <= '0;
                  sr_q   <= '0;
                  susp_q <= 1'b0;
                  if (op_legal) begin
                     err_q <= E_OK;
                     state <= S_SETUP;
                  end else begin
                     err_q <= E_SEQ;
                     state <= S_FINAL;
                  end
               end
            end
            S_SETUP: begin
               if (op_q == OP_SUSPEND)     state <= S_SETUP2;
               else if (op_q == OP_RESUME) state <= S_POLL;
               else                        state <= S_DATA;
            end
            S_SETUP2: state <= S_POLL;
            S_DATA: begin
               if (is_prog) begin
                  if (idx == last_idx) state <= S_POLL;
                  else                 idx   <= idx + 1'b1;
               end else if (is_erase) begin
                  state <= S_POLL;
               end else if (is_lock) begin
                  state <= S_IDCMD;
               end else begin
                  state <= S_FINAL;
               end
            end
            S_IDCMD: state <= S_LREAD;
            S_LREAD: begin
               err_q <= lock_match ? E_OK : E_VERIFY;
               state <= S_FINAL;
            end
            S_POLL: begin
               if (fl_rdata[7]) begin
                  sr_q <= fl_rdata[7:0];
                  if (susp_taken) begin
                     susp_q <= 1'b1;
                     state  <= S_FINAL;
                  end else begin
                     err_q <= eval_code;
                     state <= (eval_code != E_OK) ? S_CLEAR : S_FINAL;
                  end
               end else if (poll_expired) begin
                  err_q <= E_TIMEOUT;
                  state <= S_FINAL;
               end
            end
            S_CLEAR: state <= S_FINAL;
            S_FINAL: begin
               done_q <= 1'b1;
               state  <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy      = (state != S_IDLE);
   assign done      = done_q;
   assign err_code  = err_q;
   assign suspended = susp_q;

   assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));

   assert_ends_in_array_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(fl_we) && ($past(fl_wdata[7:0]) == C_ARRAY)));

   assert_clear_before_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sr_q[7] && (err_code >= 3'd1) && (err_code <= 3'd5))
         |-> ($past(fl_we, 2) && ($past(fl_wdata[7:0], 2) == C_CLRSTAT)));

   assert_supply_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sr_q[7] && sr_q[3] && !suspended) |-> (err_code == E_VPP));

   assert_op_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(op_q));

endmodule

// File: tb/tb_flash_pe_sequencer.sv
`timescale 1ns/1ps
module tb_flash_pe_sequencer;

   localparam int AW = 22;
   localparam int DW = 16;
   localparam int MAXW = 4;
   localparam int PW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_start = 1'b0;
   logic [3:0] req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [MAXW*DW-1:0] req_data = '0;
   logic [PW-1:0] poll_limit = 16'd200;
   logic busy, done, suspended, fl_we, fl_re;
   logic [2:0] err_code;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_wdata, fl_rdata;

   always #4 clk = ~clk;

   flash_pe_sequencer dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .poll_limit(poll_limit),
      .busy(busy), .done(done), .err_code(err_code), .suspended(suspended),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
      .fl_we(fl_we), .fl_re(fl_re)
   );

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   int cyc = 0;

   // Device model
   int polls = 0;
   int poll_base = 0;
   int busy_n = 0;
   logic [15:0] final_sr = 16'h0080;
   logic [15:0] lock_val = 16'h0000;
   logic [7:0] last_cmd = 8'hFF;

   always @(posedge clk) begin
      if (fl_re && last_cmd != 8'h90) polls <= polls + 1;
      if (fl_we) last_cmd <= fl_wdata[7:0];
   end

   assign fl_rdata = (last_cmd == 8'h90) ? lock_val :
                     (((polls - poll_base) < busy_n) ? 16'h0000 : final_sr);

   // Scoreboard queues
   logic [AW-1:0] qa[$];
   logic [15:0]   qd[$];
   string         qt[$];
   logic [2:0]    re_code[$];
   logic          re_susp[$];
   string         re_tag[$];

   task automatic push_w(input logic [AW-1:0] a, input logic [15:0] d, input string t);
      qa.push_back(a); qd.push_back(d); qt.push_back(t);
   endtask

   // Monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (fl_we) begin
            checks++;
            if (qa.size() == 0) begin
               errors++;
               $display("FAIL unexpected write: actual %h@%h expected none", fl_wdata, fl_addr);
            end else begin
               logic [AW-1:0] ea;
               logic [15:0] ed;
               string et;
               ea = qa.pop_front(); ed = qd.pop_front(); et = qt.pop_front();
               if (ea != fl_addr || ed != fl_wdata) begin
                  errors++;
                  $display("FAIL %s write: actual %h@%h expected %h@%h", et, fl_wdata, fl_addr, ed, ea);
               end
            end
         end
         if (done) begin
            checks++;
            if (re_code.size() == 0) begin
               errors++;
               $display("FAIL unexpected done: actual code %0d expected none", err_code);
            end else begin
               logic [2:0] ec;
               logic es;
               string et;
               ec = re_code.pop_front(); es = re_susp.pop_front(); et = re_tag.pop_front();
               if (ec != err_code || es != suspended) begin
                  errors++;
                  $display("FAIL %s result: actual code %0d susp %0d expected code %0d susp %0d",
                           et, err_code, suspended, ec, es);
               end
            end
            done_cnt++;
         end
      end
   end

   task automatic check(input bit ok, input string msg, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
      end
   endtask

   task automatic run(input logic [3:0] op, input logic [AW-1:0] a, input logic [63:0] d,
                      input logic [15:0] sr, input int bn, input logic [15:0] lv,
                      input logic [2:0] ec, input logic es, input string tag,
                      input bit nudge, input int exp_reads);
      int start_done;
      int guard;
      @(negedge clk);
      case (op)
         4'd0: begin push_w(a, 16'h40, tag); push_w(a, d[15:0], tag); end
         4'd1: begin
            push_w(a, 16'h30, tag);
            push_w({a[AW-1:1], 1'b0}, d[15:0], tag);
            push_w({a[AW-1:1], 1'b1}, d[31:16], tag);
         end
         4'd2: begin
            push_w(a, 16'h56, tag);
            for (int i = 0; i < 4; i++) push_w({a[AW-1:2], 2'(i)}, d[16*i +: 16], tag);
         end
         4'd3: begin push_w(a, 16'h20, tag); push_w(a, 16'hD0, tag); end
         4'd4: begin push_w(a, 16'hB0, tag); push_w(a, 16'h70, tag); end
         4'd5: push_w(a, 16'hD0, tag);
         4'd6, 4'd7, 4'd8: begin
            push_w(a, 16'h60, tag);
            push_w(a, (op == 4'd6) ? 16'h01 : ((op == 4'd7) ? 16'hD0 : 16'h2F), tag);
            push_w(a, 16'h90, tag);
         end
         default: ;
      endcase
      if (ec >= 3'd1 && ec <= 3'd5 && op <= 4'd5) push_w(a, 16'h50, tag);
      push_w(a, 16'hFF, tag);
      re_code.push_back(ec); re_susp.push_back(es); re_tag.push_back(tag);
      final_sr = sr; busy_n = bn; lock_val = lv; poll_base = polls;
      start_done = done_cnt;
      req_op = op; req_addr = a; req_data = d; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      if (nudge) begin
         @(negedge clk);
         req_op = 4'd3; req_addr = a ^ 22'h00F00; req_start = 1'b1;
         @(negedge clk);
         req_start = 1'b0;
      end
      guard = 0;
      while (done_cnt == start_done && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      check(done_cnt != start_done, {tag, " done seen"}, done_cnt - start_done, 1);
      check(qa.size() == 0, {tag, " all writes issued"}, qa.size(), 0);
      if (exp_reads >= 0)
         check((polls - poll_base) == exp_reads, {tag, " status reads"}, polls - poll_base, exp_reads);
      qa.delete(); qd.delete(); qt.delete();
      re_code.delete(); re_susp.delete(); re_tag.delete();
      repeat (2) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !fl_we && !fl_re && err_code == 3'd0,
            "reset state R9", {busy, done, fl_we, fl_re}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run(4'd0, 22'h012345, 64'h0000_0000_0000_BEEF, 16'h0080, 3, 0, 3'd0, 0, "R1 word", 0, 4);
      run(4'd1, 22'h000123, 64'h0000_0000_2222_1111, 16'h0080, 2, 0, 3'd0, 0, "R2 dual", 0, 3);
      run(4'd2, 22'h001235, 64'hDDDD_CCCC_BBBB_AAAA, 16'h0080, 1, 0, 3'd0, 0, "R2 quad", 0, 2);
      run(4'd3, 22'h3F0000, 64'h0, 16'h0080, 6, 0, 3'd0, 0, "R3 erase", 0, 7);
      run(4'd0, 22'h000010, 64'h1234, 16'h009A, 0, 0, 3'd1, 0, "R4 R5 vpp first", 0, 1);
      run(4'd0, 22'h000011, 64'h5678, 16'h0092, 0, 0, 3'd2, 0, "R4 prog fail", 0, 1);
      run(4'd0, 22'h000012, 64'h9ABC, 16'h00B0, 0, 0, 3'd4, 0, "R4 seq", 0, 1);
      run(4'd3, 22'h010000, 64'h0, 16'h00A0, 1, 0, 3'd3, 0, "R4 erase fail", 0, 2);
      run(4'd3, 22'h020000, 64'h0, 16'h0082, 0, 0, 3'd5, 0, "R4 R5 protected", 0, 1);
      poll_limit = 16'd5;
      run(4'd0, 22'h000020, 64'h4444, 16'h0080, 1000, 0, 3'd6, 0, "R6 timeout", 0, 5);
      poll_limit = 16'd200;
      run(4'd4, 22'h000000, 64'h0, 16'h00C0, 2, 0, 3'd0, 1, "R7 suspend taken", 0, 3);
      run(4'd4, 22'h000000, 64'h0, 16'h0084, 0, 0, 3'd0, 1, "R7 program suspend", 0, 1);
      run(4'd4, 22'h000000, 64'h0, 16'h0080, 0, 0, 3'd0, 0, "R7 suspend not taken", 0, 1);
      run(4'd5, 22'h000000, 64'h0, 16'h0080, 2, 0, 3'd0, 0, "R7 resume", 0, 3);
      run(4'd6, 22'h030000, 64'h0, 16'h0080, 0, 16'h0001, 3'd0, 0, "R8 lock", 0, 0);
      run(4'd7, 22'h030000, 64'h0, 16'h0080, 0, 16'h0001, 3'd7, 0, "R8 unlock mismatch", 0, 0);
      run(4'd8, 22'h040000, 64'h0, 16'h0080, 0, 16'h0003, 3'd0, 0, "R8 lockdown", 0, 0);
      run(4'd8, 22'h040000, 64'h0, 16'h0080, 0, 16'h0001, 3'd7, 0, "R8 lockdown mismatch", 0, 0);
      run(4'd9, 22'h000055, 64'h0, 16'h0080, 0, 0, 3'd4, 0, "R10 illegal op", 0, 0);
      run(4'd0, 22'h000077, 64'hCAFE, 16'h0080, 8, 0, 3'd0, 0, "R11 start while busy", 1, 9);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule